// File: doc/BRIEF.md
# Cascadable Reload Timer-Counter Pair

This block holds two 16-bit timer/counter channels, called A and B, behind a small word-addressed register port. Each channel has a control word, a reload value and a live count. A run-command write starts a channel, stops it, or loads the reload value into the count as it starts. A channel steps once per event. The event is either a tick from a shared internal prescaler or a selected edge on the channel's external input. That input can be inverted and passed through a two-flop synchroniser first.

When the count reaches its terminal value, the channel raises a sticky pending flag. It then either reloads (cyclic) or halts (one-shot). Pending flags are masked by enable bits onto one interrupt line per channel, and software clears them by writing ones. Setting the cascade bit in channel A's control word joins the two halves into one 32-bit unit. That unit is driven by A's settings and addressed through A's reload and count words.

Top module: `tcp_pair`

## Requirements
- R1: After reset both channels are stopped; control words, reload values, counts, interrupt enables, pending flags and `irq_o` are all zero.
- R2: Word addresses are: 0/1 control A/B, 2/3 reload A/B, 4/5 count A/B (read-only), 6/7 run command A/B (write-only), 8 interrupt enable, 9 pending (a write of 1 clears that bit). A write takes effect at the clock edge that samples `wr_en_i`. Read data appears on `rdata_o` after the edge that samples `rd_en_i` and holds until the next read.
- R3: Control bits are: 0 running status (read-only; writes are ignored), 1 direction (1 up, 0 down), 2 counter mode (1) or timer mode (0), 3 one-shot, 4 cascade (channel A only; it reads 0 in B), 5 input inversion, 7:6 edge select, 8 synchroniser enable, 9 external clock in timer mode, 10 counter-mode source (0 external edges, 1 internal tick).
- R4: Run command bits are: 0 start, 1 stop, 2 load-on-start. Stop wins over start. Start with bit 2 copies the reload value into the count. Start without bit 2 resumes from the held count. Bit 2 without start has no effect.
- R5: The internal tick fires once every PRESCALE clocks. A cyclic down-counting timer with reload R therefore reaches terminal count every (R+1)·PRESCALE clocks.
- R6: Terminal count is a count of zero when counting down and all ones when counting up. It is detected on an event. In one-shot mode the channel then stops and holds the terminal value; otherwise it reloads.
- R7: Edge select 00 counts nothing, 01 rising edges, 10 falling edges and 11 both. The edges are taken after optional inversion, so inversion swaps rising and falling.
- R8: Without the synchroniser, an input change driven between clock edges is counted at the next edge. With the synchroniser it is counted at the third edge.
- R9: In timer mode with bit 9 set, the channel counts selected external edges instead of ticks. In counter mode with bit 10 set, it counts internal ticks.
- R10: With the cascade bit set, channel A's reload and count addresses read and write 32 bits, with A in the low half and B in the high half. A borrow or carry crosses the halves. Terminal count is judged on all 32 bits and sets pending bit 0; channel B does not count on its own.
- R11: Pending bit 0 belongs to A and bit 1 to B. A pending bit is set at terminal count whatever its enable and stays set until cleared. `irq_o[i]` equals pending AND enable, delayed by one clock.
- R12: A reload value written while the channel runs leaves the live count untouched and is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | AW | Word address |
| wdata_i | input | 2·CW | Write data |
| rdata_o | output | 2·CW | Registered read data |
| ext_i | input | 2 | External count inputs, bit 0 for A, bit 1 for B |
| irq_o | output | 2 | Interrupt lines, bit 0 for A, bit 1 for B |

## Verification
Each result has a fixed due time, counted in clock edges from the edge that samples a stimulus. A register write or run command is visible at that edge. Read data is valid after it. An unsynchronised external edge steps the count at the first edge after it is driven, and a synchronised one at the third. A pending flag is set at the terminal edge and reaches `irq_o` one edge later. The bench drives all inputs and samples all outputs on falling clock edges, and checks the synchroniser and interrupt latencies at exact falling-edge counts. Tick-driven periods are measured as the distance between two interrupt rises, which does not depend on the prescaler phase.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  // control word bit positions (software decodes these)
  localparam int CB_RUN     = 0;
  localparam int CB_UP      = 1;
  localparam int CB_CNTMODE = 2;
  localparam int CB_ONESHOT = 3;
  localparam int CB_CASC    = 4;
  localparam int CB_INV     = 5;
  localparam int CB_EDGE_LO = 6;
  localparam int CB_SYNC    = 8;
  localparam int CB_EXTCLK  = 9;
  localparam int CB_SRCSEL  = 10;
  localparam int CTRL_W     = 11;

  // run command bits
  localparam int RB_START = 0;
  localparam int RB_STOP  = 1;
  localparam int RB_LOAD  = 2;

  // word address bases (channel index added where per channel)
  localparam int RA_CTRL   = 0;
  localparam int RA_RELOAD = 2;
  localparam int RA_COUNT  = 4;
  localparam int RA_RUN    = 6;
  localparam int RA_IEN    = 8;
  localparam int RA_PEND   = 9;
endpackage

// File: rtl/tcp_tick_gen.sv
module tcp_tick_gen #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] div_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (div_q == PW'(PRESCALE - 1)) div_q <= '0;
      else                            div_q <= div_q + 1'b1;
      tick_q <= (div_q == PW'(PRESCALE - 2));
    end
  end

  assign tick_o = tick_q;

  // prescaler of two or more never produces back-to-back ticks
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tcp_edge_unit.sv
module tcp_edge_unit (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic       sync_en_i,
  input  logic       invert_i,
  input  logic [1:0] edge_sel_i,
  output logic       hit_o
);
  logic s1_q, s2_q, prev_q, level;

  assign level = (sync_en_i ? s2_q : pin_i) ^ invert_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= level;
    end
  end

  always_comb begin
    unique case (edge_sel_i)
      2'b01:   hit_o = level & ~prev_q;
      2'b10:   hit_o = ~level & prev_q;
      2'b11:   hit_o = level ^ prev_q;
      default: hit_o = 1'b0;
    endcase
  end

  // an event needs the sampled level to differ from the previous one
  p_edge_needs_change_r7: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (level != prev_q));
endmodule

// File: rtl/tcp_step.sv
module tcp_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         up_i,
  output logic         term_o,
  output logic [W-1:0] next_o
);
  assign term_o = up_i ? (&val_i) : ~(|val_i);
  assign next_o = up_i ? (val_i + 1'b1) : (val_i - 1'b1);
endmodule

// File: rtl/tcp_pair.sv
module tcp_pair
  import tcp_pkg::*;
#(
  parameter int CW       = 16,
  parameter int AW       = 4,
  parameter int PRESCALE = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [2*CW-1:0] wdata_i,
  output logic [2*CW-1:0] rdata_o,
  input  logic [1:0]      ext_i,
  output logic [1:0]      irq_o
);
  localparam int DW  = 2 * CW;
  localparam int NCH = 2;

  logic [CTRL_W-1:1] ctrl_q   [NCH];
  logic [CW-1:0]     reload_q [NCH];
  logic [CW-1:0]     cnt_q    [NCH];
  logic [CW-1:0]     cnt_d    [NCH];
  logic [CW-1:0]     next16   [NCH];
  logic [NCH-1:0]    run_q, run_d, pend_q, pend_set, ien_q, irq_q;
  logic [NCH-1:0]    edge_hit, src_hit, evt, term16;
  logic [NCH-1:0]    wr_ctrl, wr_rel, wr_run;
  logic              wr_ien, wr_clr, tick, casc, term32;
  logic [DW-1:0]     next32, rd_val, rdata_q;
  logic [NCH-1:0]    clr_mask;
  logic [2:0]        cmd;

  assign casc     = ctrl_q[0][CB_CASC];
  assign wr_ien   = wr_en_i && (addr_i == AW'(RA_IEN));
  assign wr_clr   = wr_en_i && (addr_i == AW'(RA_PEND));
  assign clr_mask = wr_clr ? wdata_i[NCH-1:0] : '0;

  tcp_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick));

  tcp_step #(.W(DW)) u_step_wide (
    .val_i({cnt_q[1], cnt_q[0]}), .up_i(ctrl_q[0][CB_UP]),
    .term_o(term32), .next_o(next32));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tcp_edge_unit u_edge (
      .clk(clk), .rst(rst), .pin_i(ext_i[c]),
      .sync_en_i(ctrl_q[c][CB_SYNC]), .invert_i(ctrl_q[c][CB_INV]),
      .edge_sel_i(ctrl_q[c][CB_EDGE_LO+1:CB_EDGE_LO]), .hit_o(edge_hit[c]));

    tcp_step #(.W(CW)) u_step (
      .val_i(cnt_q[c]), .up_i(ctrl_q[c][CB_UP]),
      .term_o(term16[c]), .next_o(next16[c]));

    // timer mode: tick unless external clock; counter mode: edges unless tick chosen
    assign src_hit[c] = ctrl_q[c][CB_CNTMODE]
                      ? (ctrl_q[c][CB_SRCSEL] ? tick : edge_hit[c])
                      : (ctrl_q[c][CB_EXTCLK] ? edge_hit[c] : tick);
    // the upper half follows channel A while cascaded
    assign evt[c] = run_q[c] & src_hit[c] & ~((c != 0) & casc);

    assign wr_ctrl[c] = wr_en_i && (addr_i == AW'(RA_CTRL + c));
    assign wr_rel[c]  = wr_en_i && (addr_i == AW'(RA_RELOAD + c));
    assign wr_run[c]  = wr_en_i && (addr_i == AW'(RA_RUN + c));

    p_stop_wins_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_run[c] && wdata_i[RB_STOP]) |=> !run_q[c]);

    p_load_start_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_run[c] && wdata_i[2:0] == 3'b101) |=> (cnt_q[c] == $past(reload_q[c])));

    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (rst)
      (evt[c] && !wr_run[c] && ctrl_q[c][CB_ONESHOT] &&
       (((c == 0) && casc) ? term32 : term16[c])) |=> !run_q[c]);

    p_pend_sticky_r11: assert property (@(posedge clk) disable iff (rst)
      (pend_q[c] && !(wr_clr && wdata_i[c])) |=> pend_q[c]);
  end

  // next-state of run flags, counts and terminal events
  always_comb begin
    run_d    = run_q;
    pend_set = '0;
    cmd      = '0;
    for (int c = 0; c < NCH; c++) cnt_d[c] = cnt_q[c];
    for (int c = 0; c < NCH; c++) begin
      cmd = wr_run[c] ? wdata_i[2:0] : 3'b000;
      if (cmd[RB_STOP]) begin
        run_d[c] = 1'b0;
      end else if (cmd[RB_START]) begin
        run_d[c] = 1'b1;
        if (cmd[RB_LOAD]) begin
          cnt_d[c] = reload_q[c];
          if ((c == 0) && casc) cnt_d[1] = reload_q[1];
        end
      end else if (evt[c]) begin
        if ((c == 0) && casc) begin
          if (term32) begin
            pend_set[0] = 1'b1;
            if (ctrl_q[0][CB_ONESHOT]) run_d[0] = 1'b0;
            else begin
              cnt_d[0] = reload_q[0];
              cnt_d[1] = reload_q[1];
            end
          end else begin
            cnt_d[0] = next32[CW-1:0];
            cnt_d[1] = next32[DW-1:CW];
          end
        end else if (term16[c]) begin
          pend_set[c] = 1'b1;
          if (ctrl_q[c][CB_ONESHOT]) run_d[c] = 1'b0;
          else                       cnt_d[c] = reload_q[c];
        end else begin
          cnt_d[c] = next16[c];
        end
      end
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == AW'(RA_CTRL + c))
        rd_val = DW'({ctrl_q[c], run_q[c]});
      if (addr_i == AW'(RA_RELOAD + c))
        rd_val = ((c == 0) && casc) ? {reload_q[1], reload_q[0]} : DW'(reload_q[c]);
      if (addr_i == AW'(RA_COUNT + c))
        rd_val = ((c == 0) && casc) ? {cnt_q[1], cnt_q[0]} : DW'(cnt_q[c]);
    end
    if (addr_i == AW'(RA_IEN))  rd_val = DW'(ien_q);
    if (addr_i == AW'(RA_PEND)) rd_val = DW'(pend_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        ctrl_q[c]   <= '0;
        reload_q[c] <= '0;
        cnt_q[c]    <= '0;
      end
      run_q   <= '0;
      pend_q  <= '0;
      ien_q   <= '0;
      irq_q   <= '0;
      rdata_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        cnt_q[c] <= cnt_d[c];
        if (wr_ctrl[c]) begin
          ctrl_q[c] <= wdata_i[CTRL_W-1:1];
          if (c != 0) ctrl_q[c][CB_CASC] <= 1'b0;
        end
        if (wr_rel[c]) begin
          reload_q[c] <= wdata_i[CW-1:0];
          if ((c == 0) && casc) reload_q[1] <= wdata_i[DW-1:CW];
        end
      end
      run_q  <= run_d;
      pend_q <= (pend_q & ~clr_mask) | pend_set;
      if (wr_ien) ien_q <= wdata_i[NCH-1:0];
      irq_q  <= pend_q & ien_q;
      if (rd_en_i) rdata_q <= rd_val;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: tb/tcp_pair_test.sv
module tcp_pair_test;
  localparam int CW = 16;
  localparam int AW = 4;
  localparam int PRESCALE = 4;
  localparam int DW = 2 * CW;
  // word addresses (R2)
  localparam int AC = 0, AR = 2, AN = 4, AX = 6, AI = 8, AP = 9;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] ext = 2'b00;
  wire  [DW-1:0] rdata;
  wire  [1:0] irq;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  tcp_pair #(.CW(CW), .AW(AW), .PRESCALE(PRESCALE)) uut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ext_i(ext), .irq_o(irq));

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = AW'(a);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic expect_reg(input string req, input string what, input int a,
                            input logic [DW-1:0] e);
    logic [DW-1:0] v;
    rd(a, v);
    check(req, what, v, e);
  endtask

  task automatic pulse(input int c);
    @(negedge clk); ext[c] = 1'b1; wait_n(2);
    ext[c] = 1'b0; wait_n(2);
  endtask

  task automatic level(input int c, input logic v);
    @(negedge clk); ext[c] = v; wait_n(2);
  endtask

  task automatic period(input int c, output int p);
    int t0;
    @(negedge clk);
    while (!irq[c]) @(negedge clk);
    t0 = cyc;
    wr(AP, DW'(1) << c);
    while (irq[c]) @(negedge clk);
    while (!irq[c]) @(negedge clk);
    p = cyc - t0;
  endtask

  task automatic t_reset;
    expect_reg("R1", "ctrl A", AC, 0);
    expect_reg("R1", "ctrl B", AC + 1, 0);
    expect_reg("R1", "count A", AN, 0);
    expect_reg("R1", "reload B", AR + 1, 0);
    expect_reg("R1", "pending", AP, 0);
    expect_reg("R1", "enable", AI, 0);
    check("R1", "irq", DW'(irq), 0);
  endtask

  task automatic t_fields;
    wr(AC, 32'h7FF);
    expect_reg("R3", "ctrl A status bit not writable", AC, 32'h7FE);
    wr(AC + 1, 32'h7FF);
    expect_reg("R3", "ctrl B has no cascade bit", AC + 1, 32'h7EE);
    wr(AC, 0); wr(AC + 1, 0);
  endtask

  task automatic t_runcmd;
    wr(AC, 32'h46);            // up, counter, rising edges, external
    wr(AR, 5);
    wr(AX, 5);
    expect_reg("R3", "running status reads 1", AC, 32'h47);
    expect_reg("R4", "load on start", AN, 5);
    pulse(0); pulse(0);
    expect_reg("R4", "counts while running", AN, 7);
    wr(AX, 2);
    expect_reg("R4", "stop clears status", AC, 32'h46);
    pulse(0);
    expect_reg("R4", "stopped holds count", AN, 7);
    wr(AX, 1);
    pulse(0);
    expect_reg("R4", "resume without load", AN, 8);
    wr(AX, 4);
    expect_reg("R4", "load bit alone ignored", AN, 8);
    pulse(0);
    expect_reg("R4", "still running after load-only", AN, 9);
    wr(AX, 3);
    expect_reg("R4", "stop wins over start", AC, 32'h46);
    pulse(0);
    expect_reg("R4", "no count after stop+start", AN, 9);
  endtask

  task automatic t_edges;
    int ecode [5] = '{0, 1, 2, 3, 1};
    int einv  [5] = '{0, 0, 0, 0, 1};
    int d1    [5] = '{0, 1, 0, 1, 0};
    int d2    [5] = '{0, 0, 1, 1, 1};
    for (int k = 0; k < 5; k++) begin
      wr(AC + 1, DW'(32'h4 | (einv[k] << 5) | (ecode[k] << 6)));
      wr(AR + 1, 100);
      wr(AX + 1, 5);
      level(1, 1'b1);
      expect_reg("R7", $sformatf("after rise, case %0d", k), AN + 1, DW'(100 - d1[k]));
      level(1, 1'b0);
      expect_reg("R7", $sformatf("after fall, case %0d", k), AN + 1,
                 DW'(100 - d1[k] - d2[k]));
      wr(AX + 1, 2);
    end
  endtask

  task automatic t_sync;
    logic seen [4];
    for (int s = 0; s < 2; s++) begin
      wr(AC, (s != 0) ? 32'h146 : 32'h46);
      wr(AR, 32'hFFFF);
      wr(AP, 3);
      wr(AI, 1);
      wr(AX, 5);
      @(negedge clk); ext[0] = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); seen[k] = irq[0];
      end
      if (s == 0) begin
        check("R8", "unsynced: no irq after 1 edge", DW'(seen[0]), 0);
        check("R8", "unsynced: irq after 2 edges", DW'(seen[1]), 1);
      end else begin
        check("R8", "synced: no irq after 3 edges", DW'(seen[2]), 0);
        check("R8", "synced: irq after 4 edges", DW'(seen[3]), 1);
      end
      ext[0] = 1'b0;
      wr(AX, 2); wr(AI, 0); wr(AP, 3);
    end
  endtask

  task automatic t_timer;
    int p;
    wr(AC + 1, 0);             // timer, down, cyclic, internal tick
    wr(AR + 1, 3);
    wr(AP, 3);
    wr(AI, 2);
    wr(AX + 1, 5);
    period(1, p);
    check("R5", "tick timer period", DW'(p), DW'(4 * PRESCALE));
    wr(AX + 1, 2); wr(AI, 0); wr(AP, 3);
  endtask

  task automatic t_source;
    int p;
    wr(AC, 32'h404);           // counter mode, internal tick source, down
    wr(AR, 1);
    wr(AP, 3);
    wr(AI, 1);
    wr(AX, 5);
    period(0, p);
    check("R9", "counter mode on tick period", DW'(p), DW'(2 * PRESCALE));
    wr(AX, 2); wr(AI, 0); wr(AP, 3);
    wr(AC, 32'h240);           // timer mode, external clock, rising, down
    wr(AR, 2);
    wr(AX, 5);
    pulse(0); pulse(0);
    expect_reg("R9", "timer ext: no terminal after 2 edges", AP, 0);
    pulse(0);
    expect_reg("R9", "timer ext: terminal on 3rd edge", AP, 1);
    expect_reg("R6", "cyclic reload after terminal", AN, 2);
    wr(AX, 2); wr(AP, 3);
  endtask

  task automatic t_oneshot;
    wr(AC + 1, 32'h4E);        // up, counter, one-shot, rising
    wr(AR + 1, 32'hFFFE);
    wr(AX + 1, 5);
    pulse(1);
    expect_reg("R6", "up count to all ones", AN + 1, 32'hFFFF);
    expect_reg("R6", "no terminal before event at all ones", AP, 0);
    pulse(1);
    expect_reg("R6", "terminal at all ones", AP, 2);
    expect_reg("R6", "one-shot stops", AC + 1, 32'h4E);
    pulse(1);
    expect_reg("R6", "one-shot holds terminal value", AN + 1, 32'hFFFF);
    wr(AP, 3);
  endtask

  task automatic t_cascade;
    wr(AC, 32'h54);            // cascade, counter, rising, down
    wr(AR, 32'h0001_0000);
    wr(AX, 5);
    expect_reg("R10", "32-bit reload readback", AR, 32'h0001_0000);
    expect_reg("R10", "32-bit count loaded", AN, 32'h0001_0000);
    expect_reg("R10", "upper half in B count", AN + 1, 32'h0001);
    pulse(0);
    expect_reg("R10", "borrow across halves", AN, 32'h0000_FFFF);
    expect_reg("R10", "no terminal on low half zero", AP, 0);
    wr(AR, 0);
    wr(AX, 5);
    pulse(0);
    expect_reg("R10", "terminal on 32-bit zero sets A flag", AP, 1);
    wr(AX, 2); wr(AC, 0); wr(AP, 3);
  endtask

  task automatic t_reload_live;
    wr(AC + 1, 32'h44);        // down, counter, rising, cyclic
    wr(AR + 1, 1);
    wr(AX + 1, 5);
    wr(AR + 1, 5);
    expect_reg("R12", "count untouched by reload write", AN + 1, 1);
    pulse(1);
    expect_reg("R12", "counts down to zero", AN + 1, 0);
    pulse(1);
    expect_reg("R12", "new reload used at terminal", AN + 1, 5);
    expect_reg("R12", "terminal flagged", AP, 2);
    wr(AX + 1, 2); wr(AP, 3);
  endtask

  task automatic t_irq;
    wr(AI, 0);
    wr(AR + 1, 0);
    wr(AX + 1, 5);
    pulse(1);
    expect_reg("R11", "pending set while disabled", AP, 2);
    check("R11", "masked irq stays low", DW'(irq), 0);
    wr(AI, 2);
    wait_n(1);
    check("R11", "irq after enable", DW'(irq), 2);
    wr(AP, 1);
    expect_reg("R11", "clearing other bit keeps flag", AP, 2);
    wr(AP, 2);
    expect_reg("R11", "write one clears", AP, 0);
    wait_n(1);
    check("R11", "irq drops after clear", DW'(irq), 0);
    wr(AX + 1, 2); wr(AI, 0);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_fields();
    t_runcmd();
    t_edges();
    t_sync();
    t_timer();
    t_source();
    t_oneshot();
    t_cascade();
    t_reload_live();
    t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    total++;
    bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule